// File: doc/BRIEF.md
# Byte-Lane Programmed I2C Master

This block is a single-master I2C controller driven by one packed 32-bit command word and read back through one packed 32-bit result word. A CPU with an 8-bit data path reaches both words as four byte lanes selected by a 2-bit lane index. The three upper lanes may be loaded in any order. A store to lane 0 supplies the write data and starts the transaction. One transaction is either a register write of one byte, or a register read of one byte. A read uses a repeated start or a stop followed by a fresh start, as the command selects.

The block drives SCL and SDA as open-drain lines: an output-enable of 1 pulls the line low, and 0 releases it to the external pull-up. Both incoming lines are synchronised and glitch-filtered before use. Each SCL period is split into four equal quarters, derived from the system clock and the target SCL rate, so that data moves only while SCL is low. After reset the block waits for SDA to be seen high. It then puts a start and a stop on the bus with no clock pulse between them, and becomes ready.

The result word reports busy, separate address and data acknowledge failures, a read-complete flag with the received byte, a sticky overrun flag and the start-up waiting state.

Top module: `i2c_reg_master`

## Requirements
- R1: Command word fields: bit 31 selects read (1) or write (0); bit 30 selects a repeated start for reads; bits 22:16 hold the 7-bit target address; bits 15:8 hold the register index; bits 7:0 hold the write data. Lane n carries bits 8n+7:8n. A lane 3 value of 0x80 means read and 0x00 means write.
- R2: Stores to lanes 3, 2 and 1, in any order, only load the command and start nothing. A store to lane 0 while not busy starts a transaction.
- R3: A write sends start, address with R/W=0, register index, data byte and stop. The target register then holds the data.
- R4: A read sends start, address with R/W=0 and register index. With bit 30 set it then sends a repeated start; with bit 30 clear it sends a stop and then a start. It continues with address with R/W=1, receives one byte, answers it with a NACK and sends a stop. The result word then has bit 28 set and the byte in bits 7:0.
- R5: Result bit 31 (busy) is 1 from the lane 0 store until the closing stop is complete. Bits 25:8 read 0. Bits 7:0 read 0 unless bit 28 is set.
- R6: A missing acknowledge to either address byte sets result bit 30. The block then sends a stop, skips the remaining bytes and clears busy.
- R7: A missing acknowledge to the register index or to the write data sets result bit 29. The block then ends with a stop and the target register is left unchanged.
- R8: A lane 0 store while busy is ignored and sets result bit 27. Bit 27 stays set until the next lane 0 store that is accepted.
- R9: After reset, result bits 31 and 26 are 1 while filtered SDA is low. Once SDA is seen high, the block sends one start and one stop with no SCL pulse, then clears bits 31 and 26.
- R10: The SCL period is 4*QTR clock cycles, with QTR = CLK_HZ/(4*SCL_HZ). SDA changes while SCL is released only to form a start or a stop.
- R11: An input level is accepted only after FILT_LEN consecutive synchronised samples agree, so a one-cycle pulse is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Byte store strobe |
| addr_i | input | 2 | Byte lane index |
| wdata_i | input | 8 | Byte to store into the selected command lane |
| rdata_o | output | 8 | Selected lane of the result word |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
A table of commands is run against a behavioural target device that can refuse its address or refuse data bytes. The table covers a write, which shows the data byte landing in the addressed register, and reads with and without a repeated start, which shows that both read framings return the stored byte. A wrong address on a write and on a read separates the address-failure path from a data-byte refusal on the register index. Directed cases hold SDA low after reset, with and without a one-cycle release, to tell a genuine release from a glitch and to check that the bus reset pulses no clock. Further directed cases check lane stores that must not start anything, a lane 0 store during a transaction that must be dropped and flagged as overrun, and the measured SCL period.

// File: rtl/i2c_rm_pkg.sv
`timescale 1ns/1ps
package i2c_rm_pkg;

  typedef enum logic [3:0] {
    ST_INIT, ST_BRST, ST_IDLE, ST_START, ST_ADDRW, ST_SUB, ST_WDATA,
    ST_MIDSTOP, ST_START2, ST_RESTART, ST_ADDRR, ST_RDATA, ST_STOP
  } step_e;

  // result word bit positions
  localparam int unsigned RB_BUSY  = 31;
  localparam int unsigned RB_ANACK = 30;
  localparam int unsigned RB_DNACK = 29;
  localparam int unsigned RB_RDOK  = 28;
  localparam int unsigned RB_OVR   = 27;
  localparam int unsigned RB_INIT  = 26;

endpackage

// File: rtl/i2c_rm_filt.sv
`timescale 1ns/1ps
module i2c_rm_filt #(
  parameter int LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0]     sync_q;
  logic [LEN-1:0] hist_q;

  // reset low: a line is not trusted as released until really seen high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= '0;
      q_o    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], d_i};
      hist_q <= {hist_q[LEN-2:0], sync_q[1]};
      if (&hist_q)       q_o <= 1'b1;
      else if (~|hist_q) q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rm_regs.sv
`timescale 1ns/1ps
module i2c_rm_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       eng_busy_i,
  output logic       launch_o,
  output logic       rw_o,
  output logic       rs_o,
  output logic [6:0] taddr_o,
  output logic [7:0] sub_o,
  output logic [7:0] data_o,
  output logic       overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launch_o  <= 1'b0;
      rw_o      <= 1'b0;
      rs_o      <= 1'b0;
      taddr_o   <= '0;
      sub_o     <= '0;
      data_o    <= '0;
      overrun_o <= 1'b0;
    end else begin
      launch_o <= 1'b0;
      if (we_i) begin
        unique case (addr_i)
          2'd3: begin
            rw_o <= wdata_i[7];
            rs_o <= wdata_i[6];
          end
          2'd2: taddr_o <= wdata_i[6:0];
          2'd1: sub_o   <= wdata_i;
          default: begin
            // lane 0 is the trigger; a pending launch counts as busy
            if (eng_busy_i || launch_o) begin
              overrun_o <= 1'b1;
            end else begin
              data_o    <= wdata_i;
              launch_o  <= 1'b1;
              overrun_o <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rm_engine.sv
`timescale 1ns/1ps
module i2c_rm_engine
  import i2c_rm_pkg::*;
#(
  parameter int QTR = 31
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  logic       rw_i,
  input  logic       rs_i,
  input  logic [6:0] taddr_i,
  input  logic [7:0] sub_i,
  input  logic [7:0] data_i,
  input  logic       scl_f_i,
  input  logic       sda_f_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       frame_o,
  output logic       busy_o,
  output logic       init_o,
  output logic       anack_o,
  output logic       dnack_o,
  output logic       rdok_o,
  output logic [7:0] rdata_o
);
  localparam int CW = (QTR > 2) ? $clog2(QTR) : 1;

  step_e       step_q;
  logic [1:0]  ph_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]  bit_q;
  logic [7:0]  sh_q;
  logic        smp_q;
  logic        rw_q, rs_q;
  logic [6:0]  taddr_q;
  logic [7:0]  sub_q, data_q;

  logic running, is_byte, qend, stall, adv;
  logic scl_n, sda_n, frame_n, out_bit;

  assign running = !(step_q == ST_IDLE || step_q == ST_INIT);
  assign is_byte = step_q inside {ST_ADDRW, ST_SUB, ST_WDATA, ST_ADDRR, ST_RDATA};
  assign qend    = cnt_q == CW'(QTR - 1);
  // wait in the high quarter while a target holds SCL low
  assign stall   = (ph_q == 2'd1) && !scl_f_i && (step_q != ST_BRST);
  assign adv     = running && qend && !stall;
  assign out_bit = (step_q == ST_RDATA || bit_q == 4'd8) ? 1'b1 : sh_q[7];

  always_comb begin
    scl_n   = 1'b0;
    sda_n   = 1'b0;
    frame_n = 1'b0;
    case (step_q)
      ST_BRST: begin
        sda_n   = (ph_q == 2'd1);
        frame_n = 1'b1;
      end
      ST_START, ST_START2: begin
        scl_n   = (ph_q == 2'd3);
        sda_n   = ph_q[1];
        frame_n = 1'b1;
      end
      ST_RESTART: begin
        scl_n   = (ph_q == 2'd0) || (ph_q == 2'd3);
        sda_n   = ph_q[1];
        frame_n = 1'b1;
      end
      ST_STOP, ST_MIDSTOP: begin
        scl_n   = (ph_q == 2'd0);
        sda_n   = !ph_q[1];
        frame_n = 1'b1;
      end
      ST_ADDRW, ST_SUB, ST_WDATA, ST_ADDRR, ST_RDATA: begin
        scl_n = (ph_q == 2'd0) || (ph_q == 2'd3);
        sda_n = !out_bit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_INIT;
      ph_q     <= '0;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      smp_q    <= 1'b1;
      rw_q     <= 1'b0;
      rs_q     <= 1'b0;
      taddr_q  <= '0;
      sub_q    <= '0;
      data_q   <= '0;
      anack_o  <= 1'b0;
      dnack_o  <= 1'b0;
      rdok_o   <= 1'b0;
      rdata_o  <= '0;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
      frame_o  <= 1'b0;
    end else begin
      scl_oe_o <= scl_n;
      sda_oe_o <= sda_n;
      frame_o  <= frame_n;

      if (!running)  cnt_q <= '0;
      else if (qend) cnt_q <= stall ? cnt_q : '0;
      else           cnt_q <= cnt_q + 1'b1;

      if (adv) ph_q <= ph_q + 1'b1;

      case (step_q)
        ST_INIT: if (sda_f_i) step_q <= ST_BRST;
        ST_IDLE: begin
          if (launch_i) begin
            rw_q    <= rw_i;
            rs_q    <= rs_i;
            taddr_q <= taddr_i;
            sub_q   <= sub_i;
            data_q  <= data_i;
            anack_o <= 1'b0;
            dnack_o <= 1'b0;
            rdok_o  <= 1'b0;
            rdata_o <= '0;
            bit_q   <= '0;
            step_q  <= ST_START;
          end
        end
        default: begin
          if (adv) begin
            if (is_byte && ph_q == 2'd2) smp_q <= sda_f_i;
            if (ph_q == 2'd3) begin
              if (is_byte && bit_q != 4'd8) begin
                sh_q  <= {sh_q[6:0], smp_q};
                bit_q <= bit_q + 1'b1;
              end else begin
                bit_q <= '0;
                case (step_q)
                  ST_START: begin
                    sh_q   <= {taddr_q, 1'b0};
                    step_q <= ST_ADDRW;
                  end
                  ST_START2, ST_RESTART: begin
                    sh_q   <= {taddr_q, 1'b1};
                    step_q <= ST_ADDRR;
                  end
                  ST_MIDSTOP: step_q <= ST_START2;
                  ST_ADDRW: begin
                    if (smp_q) begin
                      anack_o <= 1'b1;
                      step_q  <= ST_STOP;
                    end else begin
                      sh_q   <= sub_q;
                      step_q <= ST_SUB;
                    end
                  end
                  ST_SUB: begin
                    if (smp_q) begin
                      dnack_o <= 1'b1;
                      step_q  <= ST_STOP;
                    end else if (rw_q) begin
                      step_q <= rs_q ? ST_RESTART : ST_MIDSTOP;
                    end else begin
                      sh_q   <= data_q;
                      step_q <= ST_WDATA;
                    end
                  end
                  ST_WDATA: begin
                    dnack_o <= smp_q;
                    step_q  <= ST_STOP;
                  end
                  ST_ADDRR: begin
                    if (smp_q) begin
                      anack_o <= 1'b1;
                      step_q  <= ST_STOP;
                    end else begin
                      step_q <= ST_RDATA;
                    end
                  end
                  ST_RDATA: begin
                    rdata_o <= sh_q;
                    rdok_o  <= 1'b1;
                    step_q  <= ST_STOP;
                  end
                  default: step_q <= ST_IDLE;
                endcase
              end
            end
          end
        end
      endcase
    end
  end

  assign busy_o = step_q != ST_IDLE;
  assign init_o = step_q == ST_INIT;
endmodule

// File: rtl/i2c_reg_master.sv
`timescale 1ns/1ps
module i2c_reg_master
  import i2c_rm_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int SCL_HZ   = 400_000,
  parameter int FILT_LEN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int QTR = CLK_HZ / (4 * SCL_HZ);

  logic [1:0] line_raw, line_f;
  logic       launch, rw, rs, overrun;
  logic [6:0] taddr;
  logic [7:0] sub, data, rdata;
  logic       eng_busy, init, anack, dnack, rdok, frame_q;
  logic [31:0] status;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_rm_filt #(.LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_f[g])
    );
  end

  i2c_rm_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .eng_busy_i(eng_busy),
    .launch_o  (launch),
    .rw_o      (rw),
    .rs_o      (rs),
    .taddr_o   (taddr),
    .sub_o     (sub),
    .data_o    (data),
    .overrun_o (overrun)
  );

  i2c_rm_engine #(.QTR(QTR)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .rw_i    (rw),
    .rs_i    (rs),
    .taddr_i (taddr),
    .sub_i   (sub),
    .data_i  (data),
    .scl_f_i (line_f[0]),
    .sda_f_i (line_f[1]),
    .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o),
    .frame_o (frame_q),
    .busy_o  (eng_busy),
    .init_o  (init),
    .anack_o (anack),
    .dnack_o (dnack),
    .rdok_o  (rdok),
    .rdata_o (rdata)
  );

  always_comb begin
    status           = '0;
    status[RB_BUSY]  = eng_busy | launch;
    status[RB_ANACK] = anack;
    status[RB_DNACK] = dnack;
    status[RB_RDOK]  = rdok;
    status[RB_OVR]   = overrun;
    status[RB_INIT]  = init;
    status[7:0]      = rdata;
  end

  assign rdata_o = status[{addr_i, 3'b000} +: 8];
endmodule

// File: rtl/i2c_rm_chk.sv
`timescale 1ns/1ps
module i2c_rm_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic [31:0] status_i,
  input logic        scl_oe_i,
  input logic        sda_oe_i,
  input logic        frame_i
);
  a_r9_init_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[26] |-> status_i[31]);

  a_r8_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0 && status_i[31]) |=> status_i[27]);

  a_r8_overrun_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0 && !status_i[31]) |=> (status_i[31] && !status_i[27]));

  a_r5_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i[31] |-> (!scl_oe_i && !sda_oe_i));

  a_r4_read_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[28] |-> !(status_i[30] || status_i[29]));

  a_r10_sda_when_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_i) && !scl_oe_i) |-> frame_i);
endmodule

bind i2c_reg_master i2c_rm_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .status_i(status),
  .scl_oe_i(scl_oe_o),
  .sda_oe_i(sda_oe_o),
  .frame_i (frame_q)
);

// File: tb/i2c_reg_master_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_master_tb_top;
  localparam int CLK_HZ = 50_000_000;
  localparam int SCL_HZ = 400_000;
  localparam int Q      = CLK_HZ / (4 * SCL_HZ);
  localparam logic [6:0] SLV = 7'h50;

  typedef struct packed {
    logic [31:0] cmd;
    logic        na;
    logic        nd;
    logic [31:0] exp;
    logic        chk;
    logic [3:0]  idx;
    logic [7:0]  val;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0050_03A5, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 4'd3, 8'hA5},
    '{32'hC050_0300, 1'b0, 1'b0, 32'h1000_00A5, 1'b0, 4'd0, 8'h00},
    '{32'h0050_073C, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 4'd7, 8'h3C},
    '{32'h8050_0700, 1'b0, 1'b0, 32'h1000_003C, 1'b0, 4'd0, 8'h00},
    '{32'h0051_0455, 1'b0, 1'b0, 32'h4000_0000, 1'b1, 4'd4, 8'h44},
    '{32'hC051_0300, 1'b0, 1'b0, 32'h4000_0000, 1'b0, 4'd0, 8'h00},
    '{32'h0050_0566, 1'b0, 1'b1, 32'h2000_0000, 1'b1, 4'd5, 8'h55},
    '{32'hC050_0300, 1'b0, 1'b1, 32'h2000_0000, 1'b0, 4'd0, 8'h00}
  };

  function automatic string req_of(int i);
    case (i)
      0, 2:    return "R1 R3";
      1:       return "R1 R4 repeated start";
      3:       return "R4 stop-start read";
      4:       return "R6 write";
      5:       return "R6 R5 read";
      default: return "R7";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       scl_oe, sda_oe;
  logic       hold_sda = 1'b1;
  logic       s_drv = 1'b0;
  logic       scl_bus, sda_bus;

  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | s_drv | hold_sda);

  i2c_reg_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .FILT_LEN(3)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .scl_i   (scl_bus),
    .sda_i   (sda_bus),
    .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe)
  );

  // behavioural target device
  logic [7:0] mem [16];
  logic       s_act = 1'b0, s_rd = 1'b0, s_mack = 1'b1;
  logic       nack_a = 1'b0, nack_d = 1'b0;
  int         s_cnt = 0, s_bytes = 0;
  logic [7:0] s_sh = 8'd0, s_tx = 8'd0;
  logic [3:0] s_ptr = 4'd0;
  logic       ps = 1'b1, pd = 1'b1;
  int         n_start = 0, n_stop = 0, n_sclf = 0;
  time        rise_prev = 0, rise_last = 0;

  initial for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17);

  always @(scl_bus or sda_bus) begin
    if (scl_bus && ps && pd && !sda_bus) begin
      n_start++;
      s_act = 1'b1; s_cnt = 0; s_bytes = 0; s_rd = 1'b0; s_drv = 1'b0;
    end else if (scl_bus && ps && !pd && sda_bus) begin
      n_stop++;
      s_act = 1'b0; s_drv = 1'b0;
    end else if (s_act && scl_bus && !ps) begin
      if (s_cnt < 8) s_sh = {s_sh[6:0], sda_bus};
      s_cnt++;
      if (s_cnt == 9 && s_rd) s_mack = sda_bus;
    end else if (s_act && !scl_bus && ps) begin
      if (s_cnt == 8) begin
        if (s_bytes == 0) begin
          if (s_sh[7:1] == SLV && !nack_a) begin
            s_drv = 1'b1; s_rd = s_sh[0]; s_mack = 1'b0;
          end else begin
            s_act = 1'b0; s_drv = 1'b0;
          end
        end else if (s_rd) begin
          s_drv = 1'b0;
        end else if (nack_d) begin
          s_act = 1'b0; s_drv = 1'b0;
        end else begin
          if (s_bytes == 1) s_ptr = s_sh[3:0];
          else begin mem[s_ptr] = s_sh; s_ptr = s_ptr + 1'b1; end
          s_drv = 1'b1;
        end
      end else if (s_cnt == 9) begin
        s_cnt = 0;
        s_bytes++;
        if (s_rd && !s_mack) begin
          s_tx = mem[s_ptr]; s_ptr = s_ptr + 1'b1; s_drv = !s_tx[7];
        end else s_drv = 1'b0;
      end else if (s_rd && s_cnt >= 1 && s_cnt <= 7) begin
        s_drv = !s_tx[7 - s_cnt];
      end
    end
    ps = scl_bus;
    pd = sda_bus;
  end

  always @(negedge scl_bus) n_sclf++;
  always @(posedge scl_bus) begin rise_prev = rise_last; rise_last = $time; end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_lane(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_stat(output logic [31:0] s);
    for (int l = 0; l < 4; l++) begin
      addr = 2'(l);
      #1;
      s[8*l +: 8] = rdata;
    end
  endtask

  task automatic launch(input logic [31:0] c);
    wr_lane(2'd2, c[23:16]);
    wr_lane(2'd1, c[15:8]);
    wr_lane(2'd3, c[31:24]);
    wr_lane(2'd0, c[7:0]);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      addr = 2'd3;
      #1;
      if (!rdata[7]) break;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] st;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    rd_stat(st);
    chk(st == 32'h8400_0000, "R9 waiting while SDA low", st, 32'h8400_0000);

    // one-cycle release must not count as SDA high
    @(negedge clk); hold_sda = 1'b0;
    @(negedge clk); hold_sda = 1'b1;
    repeat (20) @(negedge clk);
    rd_stat(st);
    chk(st == 32'h8400_0000, "R11 glitch rejected", st, 32'h8400_0000);

    @(negedge clk); hold_sda = 1'b0;
    #1; n_start = 0; n_stop = 0; n_sclf = 0;
    wait_idle();
    repeat (5) @(negedge clk);
    rd_stat(st);
    chk(st == 32'h0, "R9 ready after bus reset", st, 32'h0);
    chk(n_start == 1 && n_stop == 1, "R9 one start one stop", 32'(n_start * 16 + n_stop), 32'h11);
    chk(n_sclf == 0, "R9 no SCL pulse", 32'(n_sclf), 32'h0);

    // upper lanes alone start nothing
    wr_lane(2'd1, 8'h03);
    wr_lane(2'd3, 8'h00);
    wr_lane(2'd2, 8'h50);
    repeat (300) @(negedge clk);
    rd_stat(st);
    chk(st == 32'h0, "R2 upper lanes no launch", st, 32'h0);
    chk(n_sclf == 0, "R2 bus quiet", 32'(n_sclf), 32'h0);

    for (int i = 0; i < 8; i++) begin
      nack_a = VECS[i].na;
      nack_d = VECS[i].nd;
      launch(VECS[i].cmd);
      wait_idle();
      rd_stat(st);
      chk(st == VECS[i].exp, req_of(i), st, VECS[i].exp);
      if (VECS[i].chk)
        chk(mem[VECS[i].idx] == VECS[i].val, req_of(i), 32'(mem[VECS[i].idx]), 32'(VECS[i].val));
      nack_a = 1'b0;
      nack_d = 1'b0;
    end

    chk((rise_last - rise_prev) == time'(4 * Q * 20), "R10 SCL period",
        32'(rise_last - rise_prev), 32'(4 * Q * 20));

    // overrun
    launch(32'h0050_0911);
    repeat (50) @(negedge clk);
    wr_lane(2'd0, 8'h22);
    rd_stat(st);
    chk(st[31] && st[27], "R8 overrun while busy", st, 32'h8800_0000);
    wait_idle();
    rd_stat(st);
    chk(st == 32'h0800_0000, "R8 overrun sticky", st, 32'h0800_0000);
    chk(mem[9] == 8'h11, "R8 dropped store ignored", 32'(mem[9]), 32'h11);
    launch(32'hC050_0900);
    wait_idle();
    rd_stat(st);
    chk(st == 32'h1000_0011, "R8 cleared by accepted launch", st, 32'h1000_0011);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule